// File: doc/BRIEF.md
# Four-Cable Word Time Multiplexer

This block takes four 40-bit cable words that all arrive once per slow bunch-clock period and sends them out one after another on a single 40-bit bus. The bus runs on a fast clock at four times the slow rate, so each cable gets one fast-clock slot in every slow period. Each cable word holds four 10-bit energy values for the towers on that cable. The block passes these words through bit for bit and never looks inside them.

Both the slow clock and the cable words are sampled in the fast clock domain. The fast clock is assumed to be phase-locked to the slow clock. A rising slow-clock edge is seen on the fast edge where the slow clock reads high after reading low on the previous fast edge. That edge does three things: it captures all four words, it restarts a slot counter, and it aligns the output so that slot 0 always carries cable 0. Next to the data word the block drives a slot index and a valid strobe, so the receiver can tell which cable each word came from. After reset the counter does nothing until the first slow edge. From then on it runs freely and realigns at every slow edge.

Top module: `quad_cable_tmux`

## Requirements
- R1: While `rst` is high at a fast clock edge, the outputs after that edge are `mux_valid`=0, `mux_slot`=0 and `mux_word`=0.
- R2: A slow edge is recognized only when `slow_clk` is sampled 1 and the previous fast sample was 0. If `slow_clk` is already high when reset is released, that is not an edge, and `mux_valid` stays 0 until a real low-to-high transition is sampled.
- R3: Cable words are captured only at a recognized slow edge. Changing `cable_words` at any other fast edge does not change any word sent out in that period.
- R4: On the fast cycle after a recognized edge is registered, the outputs are `mux_slot`=0, `mux_valid`=1, and `mux_word` equal to cable 0's captured word (`cable_words[0]`).
- R5: On each later fast cycle with no new edge, `mux_slot` goes up by one and `mux_word` carries the captured word of cable `mux_slot`. After slot 3 the slot index wraps to 0.
- R6: All 40 bits of each word are sent out unchanged, whatever the values in its four 10-bit fields.
- R7: `mux_valid` is 0 from reset until the first recognized edge. After that it stays 1 on every cycle until the next reset.
- R8: A recognized edge at any slot position restarts the sequence, so slot 0 with the new cable 0 word appears on the following output cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four times the slow rate and phase-locked to it |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk | input | 1 | Slow bunch clock, sampled as data |
| cable_words | input | 4x40 | One word per cable; index c is cable c |
| mux_word | output | 40 | Time-multiplexed cable word |
| mux_slot | output | 2 | Cable index of the word currently on `mux_word` |
| mux_valid | output | 1 | High once the sequence has locked to a slow edge |

## Verification
The bench builds the block with its default parameters: four cables and 40-bit words. With these values the whole slot cycle is only four fast cycles long, so every slot position, every wrap and every alignment of reset release against the slow clock can be swept exhaustively in a short run. It drives random words that change on every fast cycle to show that only the captured word reaches the bus. It also sends field patterns that exercise all four 10-bit fields of each word. Finally it shortens and stretches the slow period to force realignment from different slot positions.

// File: rtl/quad_tmux_pkg.sv
package quad_tmux_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/slow_edge_detect.sv
module slow_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic slow_clk,
  output logic rise
);
  logic slow_q;

  // The sample is preset high so that a slow clock already high at release is not an edge.
  always_ff @(posedge clk) begin
    if (rst) slow_q <= 1'b1;
    else     slow_q <= slow_clk;
  end

  assign rise = !rst && slow_clk && !slow_q;
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import quad_tmux_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  output logic [SLOT_W-1:0] slot,
  output logic              running
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  seq_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      slot  <= '0;
    end else if (rise) begin
      state <= SEQ_RUN;
      slot  <= '0;
    end else if (state == SEQ_RUN) begin
      slot <= (slot == LAST) ? '0 : slot + SLOT_W'(1);
    end
  end

  assign running = (state == SEQ_RUN);

  p_idle_parked_r7: assert property (@(posedge clk) disable iff (rst)
    (!running && !rise) |=> (slot == '0));
endmodule

// File: rtl/word_capture.sv
module word_capture #(
  parameter int NUM_CABLES = 4,
  parameter int WORD_W     = 40
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rise,
  input  logic [NUM_CABLES-1:0][WORD_W-1:0] cable_words,
  output logic [NUM_CABLES-1:0][WORD_W-1:0] held
);
  for (genvar c = 0; c < NUM_CABLES; c++) begin : g_cable
    always_ff @(posedge clk) begin
      if (rst)       held[c] <= '0;
      else if (rise) held[c] <= cable_words[c];
    end
  end

  p_hold_between_edges_r3: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(held));
endmodule

// File: rtl/slot_output.sv
module slot_output #(
  parameter int NUM_CABLES = 4,
  parameter int WORD_W     = 40,
  localparam int SLOT_W = (NUM_CABLES > 1) ? $clog2(NUM_CABLES) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [SLOT_W-1:0]                slot,
  input  logic                             running,
  input  logic [NUM_CABLES-1:0][WORD_W-1:0] held,
  output logic [WORD_W-1:0]                mux_word,
  output logic [SLOT_W-1:0]                mux_slot,
  output logic                             mux_valid
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_CABLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_word  <= '0;
      mux_slot  <= '0;
      mux_valid <= 1'b0;
    end else begin
      mux_word  <= running ? held[slot] : '0;
      mux_slot  <= slot;
      mux_valid <= running;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!mux_valid && mux_slot == '0 && mux_word == '0));

  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    mux_valid |=> mux_valid);

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (mux_valid && mux_slot == LAST) |=> (mux_slot == '0));

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (mux_valid && mux_slot != LAST) |=>
      (mux_slot == '0 || mux_slot == $past(mux_slot) + SLOT_W'(1)));
endmodule

// File: rtl/quad_cable_tmux.sv
module quad_cable_tmux #(
  parameter int NUM_CABLES = 4,
  parameter int WORD_W     = 40,
  localparam int SLOT_W = (NUM_CABLES > 1) ? $clog2(NUM_CABLES) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             slow_clk,
  input  logic [NUM_CABLES-1:0][WORD_W-1:0] cable_words,
  output logic [WORD_W-1:0]                mux_word,
  output logic [SLOT_W-1:0]                mux_slot,
  output logic                             mux_valid
);
  logic                             rise;
  logic [SLOT_W-1:0]                slot;
  logic                             running;
  logic [NUM_CABLES-1:0][WORD_W-1:0] held;

  slow_edge_detect u_edge (
    .clk      (clk),
    .rst      (rst),
    .slow_clk (slow_clk),
    .rise     (rise)
  );

  slot_sequencer #(.NUM_SLOTS(NUM_CABLES)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .rise    (rise),
    .slot    (slot),
    .running (running)
  );

  word_capture #(.NUM_CABLES(NUM_CABLES), .WORD_W(WORD_W)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .rise        (rise),
    .cable_words (cable_words),
    .held        (held)
  );

  slot_output #(.NUM_CABLES(NUM_CABLES), .WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .slot      (slot),
    .running   (running),
    .held      (held),
    .mux_word  (mux_word),
    .mux_slot  (mux_slot),
    .mux_valid (mux_valid)
  );

  // Two registers lie between a sampled edge and the output bus.
  p_realign_r8: assert property (@(posedge clk) disable iff (rst)
    rise |=> ##1 (mux_valid && mux_slot == '0));

  p_first_slot_r4: assert property (@(posedge clk) disable iff (rst)
    rise |=> ##1 (mux_word == $past(cable_words[0], 2)));
endmodule

// File: tb/quad_cable_tmux_test.sv
module quad_cable_tmux_test;
  localparam int NC = 4;
  localparam int WW = 40;
  typedef logic [NC-1:0][WW-1:0] words_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slow_clk = 1'b0;
  words_t        cable_words = '0;
  logic [WW-1:0] mux_word;
  logic [1:0]    mux_slot;
  logic          mux_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Model of the requirement-level behaviour
  bit            have_exp = 0;
  bit            exp_from_rst = 0;
  logic          e_valid;
  logic [1:0]    e_slot;
  logic [WW-1:0] e_word;
  bit            m_run = 0;
  int            m_pos = 0;
  bit            m_prev = 1;
  words_t        m_cap = '0;
  string         phase_tag = "";
  int            sphase = 0;

  quad_cable_tmux uut (
    .clk         (clk),
    .rst         (rst),
    .slow_clk    (slow_clk),
    .cable_words (cable_words),
    .mux_word    (mux_word),
    .mux_slot    (mux_slot),
    .mux_valid   (mux_valid)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s%s %s act=%h exp=%h", tag, phase_tag, what, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] rnd_word();
    return WW'({$urandom, $urandom});
  endfunction

  function automatic words_t rnd_words();
    words_t w;
    for (int c = 0; c < NC; c++) w[c] = rnd_word();
    return w;
  endfunction

  // One fast cycle: check the outputs of the last edge, drive, and predict the next edge.
  task automatic step(input logic r, input logic s, input words_t w);
    string tw, ts;
    @(negedge clk);
    if (have_exp) begin
      if (exp_from_rst) begin
        tw = "R1"; ts = "R1";
      end else if (e_valid && e_slot == 2'd0) begin
        tw = "R4"; ts = "R4";
      end else begin
        tw = "R3"; ts = "R5";
      end
      chk(exp_from_rst ? "R1" : "R7", "mux_valid", WW'(mux_valid), WW'(e_valid));
      chk(ts, "mux_slot", WW'(mux_slot), WW'(e_slot));
      chk(tw, "mux_word", mux_word, e_word);
    end
    rst = r;
    slow_clk = s;
    cable_words = w;
    if (r) begin
      exp_from_rst = 1;
      e_valid = 0; e_slot = 0; e_word = '0;
      m_run = 0; m_pos = 0; m_prev = 1;
    end else begin
      exp_from_rst = 0;
      e_valid = m_run;
      e_slot  = m_run ? 2'(m_pos) : 2'd0;
      e_word  = m_run ? m_cap[m_pos] : '0;
      if (s && !m_prev) begin
        m_cap = w; m_pos = 0; m_run = 1;
      end else if (m_run) begin
        m_pos = (m_pos + 1) % NC;
      end
      m_prev = s;
    end
    have_exp = 1;
  endtask

  function automatic logic next_level(input int hi, input int lo);
    logic v;
    v = (sphase % (hi + lo)) < hi;
    sphase++;
    return v;
  endfunction

  // Run slow periods with fresh random words on every fast cycle.
  task automatic run_random(input int cycles, input int hi, input int lo);
    for (int i = 0; i < cycles; i++) step(1'b0, next_level(hi, lo), rnd_words());
  endtask

  function automatic words_t pattern(input int k);
    words_t w;
    for (int c = 0; c < NC; c++)
      for (int f = 0; f < 4; f++) begin
        logic [9:0] v;
        case (k)
          0: v = 10'h3FF;
          1: v = (f == c) ? 10'h3FF : 10'h000;
          2: v = 10'((c * 4 + f) * 37 + 1);
          default: v = ((c + f) % 2 == 0) ? 10'h155 : 10'h2AA;
        endcase
        w[c][f*10 +: 10] = v;
      end
    return w;
  endfunction

  initial begin
    // R1: reset with the slow clock running
    sphase = 0;
    for (int i = 0; i < 4; i++) step(1'b1, next_level(2, 2), rnd_words());
    sphase = 2; // release while the slow clock is low
    run_random(160, 2, 2);

    // R6: directed field patterns held steady across periods
    phase_tag = "/R6";
    for (int k = 0; k < 4; k++) begin
      words_t p;
      p = pattern(k);
      for (int i = 0; i < 8; i++) step(1'b0, next_level(2, 2), p);
    end
    phase_tag = "";

    // R2: release reset at every phase of the slow clock
    phase_tag = "/R2";
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 2; i++) step(1'b1, next_level(2, 2), rnd_words());
      sphase = ph;
      run_random(16, 2, 2);
    end
    phase_tag = "";

    // R8: realign from every slot position with shortened periods
    phase_tag = "/R8";
    for (int cut = 1; cut <= 4; cut++) begin
      sphase = 0;
      run_random(8, 2, 2);
      for (int i = 0; i < cut; i++) step(1'b0, (i == 0), rnd_words());
      step(1'b0, 1'b0, rnd_words());
      sphase = 0;
      run_random(12, 2, 2);
    end
    // stretched period: counter wraps freely before the next edge
    sphase = 0;
    run_random(36, 3, 3);
    sphase = 0;
    run_random(20, 1, 1);
    phase_tag = "";

    step(1'b0, 1'b0, rnd_words());
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(10 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule